// File: doc/BRIEF.md
# Converter Test Bus Multiplexer

This block sits in the digital shell of a multi-step data converter and drives a 14-bit test bus that goes out to device pins. It selects one source for the bus. The first source is the full 12-bit conversion result, together with its underflow and overflow flags. The next three are the coarse (4-bit), mid (4-bit) and fine (6-bit) sub-converter outputs, each shown on its own. The last is scan data from the digital logic, used in digital test. The bus is registered once on the converter clock, so the tester samples data that is aligned to that clock.

The selection comes from latched test-control bits: a two-bit source code and a scan-mode bit that overrides the code. In the other direction, the inbound test rail carries scan data from the pins into the logic. Every shell I/O bit passes through a hold cell, which is a flop with a test-enable mux. Separate hold controls for the outbound and inbound sides let the shell freeze its I/O, and so isolate itself from neighbouring cores.

Top module: `cnvTestBus`

## Requirements
- R1: While rstN is low, testRailOut and the inbound scan outputs (scanSiPar, scanSiSer) are all zero.
- R2: When scanMode is 1, testRailOut one clock later is {scanSoSer, scanSoPar[12:0]}, with the serial bit on bit 13. This holds whatever modeSel is.
- R3: When scanMode is 0 and modeSel is 00, testRailOut one clock later is {overIn, underIn, resultIn[11:0]}. Overflow is on bit 13 and underflow is on bit 12.
- R4: When scanMode is 0 and modeSel is 01, testRailOut one clock later carries coarseIn on bits 3:0. Bits 13:4 are zero.
- R5: When scanMode is 0 and modeSel is 10, testRailOut one clock later carries midIn on bits 3:0. Bits 13:4 are zero.
- R6: When scanMode is 0 and modeSel is 11, testRailOut one clock later carries fineIn on bits 5:0. Bits 13:6 are zero.
- R7: While holdOut is 1, testRailOut keeps its last captured value, whatever the sources and mode do. After holdOut is released, the next clock loads the current selection again.
- R8: When holdIn is 0, each clock loads testRailIn into the inbound cells: scanSiPar gets bits 12:0 and scanSiSer gets bit 13. While holdIn is 1, the inbound cells keep their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rstN | input | 1 | Asynchronous reset, active low |
| scanMode | input | 1 | Scan transport select; overrides modeSel |
| modeSel | input | 2 | Source code: 00 result, 01 coarse, 10 mid, 11 fine |
| holdOut | input | 1 | Freezes the outbound hold cells |
| holdIn | input | 1 | Freezes the inbound hold cells |
| resultIn | input | 12 | Full conversion result |
| underIn | input | 1 | Underflow flag |
| overIn | input | 1 | Overflow flag |
| coarseIn | input | 4 | Coarse sub-converter output |
| midIn | input | 4 | Mid sub-converter output |
| fineIn | input | 6 | Fine sub-converter output |
| scanSoPar | input | 13 | Parallel scan data from the logic |
| scanSoSer | input | 1 | Serial scan data from the logic |
| testRailIn | input | 14 | Inbound test rail from the pins |
| testRailOut | output | 14 | Registered outbound test bus |
| scanSiPar | output | 13 | Parallel scan data to the logic |
| scanSiSer | output | 1 | Serial scan data to the logic |

## Verification
The hardest case to reach is a hold that really blocks a change. If the sources are steady while the hold is high, the hold test proves nothing. The stimulus therefore loads a known word, raises the hold control, and then changes both the selected source and the mode for several clocks. It checks that the rail has not moved, and after release it checks that the new value appears exactly one clock later. For the inbound side, the test changes testRailIn while holdIn is high in the same way. In a second case, scan mode is raised while modeSel points at each sub-converter in turn, to show that scan data still takes priority.

// File: rtl/cnv_test_bus_pkg.sv
package cnv_test_bus_pkg;

  typedef enum logic [1:0] {
    SRC_RESULT = 2'b00,
    SRC_COARSE = 2'b01,
    SRC_MID    = 2'b10,
    SRC_FINE   = 2'b11
  } srcSel_e;

  typedef struct packed {
    logic selScan;
    logic selResult;
    logic selCoarse;
    logic selMid;
    logic selFine;
    logic loadOut;
    logic loadIn;
  } busStrobes_t;

endpackage

// File: rtl/cnvHoldCell.sv
module cnvHoldCell (
  input  logic clk,
  input  logic rstN,
  input  logic testEn,
  input  logic funcD,
  input  logic testD,
  output logic q
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) q <= 1'b0;
    else       q <= testEn ? testD : funcD;
  end

endmodule

// File: rtl/cnvBusCtrl.sv
module cnvBusCtrl
  import cnv_test_bus_pkg::*;
(
  input  logic        scanMode,
  input  logic [1:0]  modeSel,
  input  logic        holdOut,
  input  logic        holdIn,
  output busStrobes_t strobes
);

  srcSel_e srcCode;

  always_comb begin
    srcCode           = srcSel_e'(modeSel);
    strobes           = '0;
    strobes.selScan   = scanMode;
    strobes.selResult = !scanMode && (srcCode == SRC_RESULT);
    strobes.selCoarse = !scanMode && (srcCode == SRC_COARSE);
    strobes.selMid    = !scanMode && (srcCode == SRC_MID);
    strobes.selFine   = !scanMode && (srcCode == SRC_FINE);
    strobes.loadOut   = !holdOut;
    strobes.loadIn    = !holdIn;
  end

endmodule

// File: rtl/cnvBusDatapath.sv
module cnvBusDatapath
  import cnv_test_bus_pkg::*;
#(
  parameter int RES_W  = 12,
  parameter int CRS_W  = 4,
  parameter int MID_W  = 4,
  parameter int FIN_W  = 6,
  localparam int BUS_W  = RES_W + 2,
  localparam int SCAN_W = BUS_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobes_t       strobes,
  input  logic [RES_W-1:0]  resultIn,
  input  logic              underIn,
  input  logic              overIn,
  input  logic [CRS_W-1:0]  coarseIn,
  input  logic [MID_W-1:0]  midIn,
  input  logic [FIN_W-1:0]  fineIn,
  input  logic [SCAN_W-1:0] scanSoPar,
  input  logic              scanSoSer,
  input  logic [BUS_W-1:0]  testRailIn,
  output logic [BUS_W-1:0]  testRailOut,
  output logic [SCAN_W-1:0] scanSiPar,
  output logic              scanSiSer
);

  logic [BUS_W-1:0] busNext;
  logic [BUS_W-1:0] inQ;

  always_comb begin
    busNext = '0;
    if (strobes.selScan)        busNext = {scanSoSer, scanSoPar};
    else if (strobes.selResult) busNext = {overIn, underIn, resultIn};
    else if (strobes.selCoarse) busNext[CRS_W-1:0] = coarseIn;
    else if (strobes.selMid)    busNext[MID_W-1:0] = midIn;
    else if (strobes.selFine)   busNext[FIN_W-1:0] = fineIn;
  end

  for (genvar i = 0; i < BUS_W; i++) begin : gOutCell
    cnvHoldCell uOut (
      .clk   (clk),
      .rstN  (rstN),
      .testEn(!strobes.loadOut),
      .funcD (busNext[i]),
      .testD (testRailOut[i]),
      .q     (testRailOut[i])
    );
  end

  for (genvar i = 0; i < BUS_W; i++) begin : gInCell
    cnvHoldCell uIn (
      .clk   (clk),
      .rstN  (rstN),
      .testEn(!strobes.loadIn),
      .funcD (testRailIn[i]),
      .testD (inQ[i]),
      .q     (inQ[i])
    );
  end

  assign scanSiPar = inQ[SCAN_W-1:0];
  assign scanSiSer = inQ[BUS_W-1];

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadOut |=> $stable(testRailOut)); // R7
  AST_IN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadIn |=> $stable(inQ)); // R8
  AST_SCAN_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    strobes.selScan && strobes.loadOut |=> testRailOut == $past({scanSoSer, scanSoPar})); // R2
  AST_RESULT_PASS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.selResult && strobes.loadOut |=> testRailOut == $past({overIn, underIn, resultIn})); // R3
  AST_CRS_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    strobes.selCoarse && strobes.loadOut |=> testRailOut[BUS_W-1:CRS_W] == '0); // R4
  AST_MID_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    strobes.selMid && strobes.loadOut |=> testRailOut[BUS_W-1:MID_W] == '0); // R5
  AST_FINE_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    strobes.selFine && strobes.loadOut |=> testRailOut[BUS_W-1:FIN_W] == '0); // R6
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |-> (testRailOut == '0 && inQ == '0)); // R1

endmodule

// File: rtl/cnvTestBus.sv
module cnvTestBus
  import cnv_test_bus_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int CRS_W = 4,
  parameter int MID_W = 4,
  parameter int FIN_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               scanMode,
  input  logic [1:0]         modeSel,
  input  logic               holdOut,
  input  logic               holdIn,
  input  logic [RES_W-1:0]   resultIn,
  input  logic               underIn,
  input  logic               overIn,
  input  logic [CRS_W-1:0]   coarseIn,
  input  logic [MID_W-1:0]   midIn,
  input  logic [FIN_W-1:0]   fineIn,
  input  logic [RES_W:0]     scanSoPar,
  input  logic               scanSoSer,
  input  logic [RES_W+1:0]   testRailIn,
  output logic [RES_W+1:0]   testRailOut,
  output logic [RES_W:0]     scanSiPar,
  output logic               scanSiSer
);

  busStrobes_t strobes;

  cnvBusCtrl uCtrl (
    .scanMode(scanMode),
    .modeSel (modeSel),
    .holdOut (holdOut),
    .holdIn  (holdIn),
    .strobes (strobes)
  );

  cnvBusDatapath #(
    .RES_W(RES_W), .CRS_W(CRS_W), .MID_W(MID_W), .FIN_W(FIN_W)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .resultIn   (resultIn),
    .underIn    (underIn),
    .overIn     (overIn),
    .coarseIn   (coarseIn),
    .midIn      (midIn),
    .fineIn     (fineIn),
    .scanSoPar  (scanSoPar),
    .scanSoSer  (scanSoSer),
    .testRailIn (testRailIn),
    .testRailOut(testRailOut),
    .scanSiPar  (scanSiPar),
    .scanSiSer  (scanSiSer)
  );

endmodule

// File: tb/sim_cnvTestBus.sv
module sim_cnvTestBus;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scanMode = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic holdOut = 1'b0, holdIn = 1'b0;
  logic [11:0] resultIn = '0;
  logic underIn = 1'b0, overIn = 1'b0;
  logic [3:0] coarseIn = '0, midIn = '0;
  logic [5:0] fineIn = '0;
  logic [12:0] scanSoPar = '0;
  logic scanSoSer = 1'b0;
  logic [13:0] testRailIn = '0;
  logic [13:0] testRailOut;
  logic [12:0] scanSiPar;
  logic scanSiSer;

  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cnvTestBus u0 (.*);

  task automatic chk(input string req, input logic [13:0] got, input logic [13:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tReset();
    testRailIn = 14'h3FFF; resultIn = 12'hFFF; overIn = 1'b1;
    step(2);
    chk("R1 rail out", testRailOut, 14'h0);
    chk("R1 inbound", {scanSiSer, scanSiPar}, 14'h0);
    rstN = 1'b1;
    step(1);
  endtask

  task automatic tResult();
    scanMode = 0; modeSel = 2'b00;
    resultIn = 12'hA5C; underIn = 1; overIn = 0;
    step(1);
    chk("R3 under", testRailOut, 14'h1A5C);
    resultIn = 12'h3E1; underIn = 0; overIn = 1;
    step(1);
    chk("R3 over", testRailOut, 14'h23E1);
  endtask

  task automatic tSubs();
    coarseIn = 4'hB; midIn = 4'h6; fineIn = 6'h2D; resultIn = 12'hFFF;
    underIn = 1; overIn = 1;
    modeSel = 2'b01; step(1);
    chk("R4 coarse", testRailOut, 14'h000B);
    modeSel = 2'b10; step(1);
    chk("R5 mid", testRailOut, 14'h0006);
    modeSel = 2'b11; step(1);
    chk("R6 fine", testRailOut, 14'h002D);
    fineIn = 6'h3F; step(1);
    chk("R6 fine full", testRailOut, 14'h003F);
  endtask

  task automatic tScan();
    scanSoPar = 13'h1234; scanSoSer = 1; scanMode = 1;
    for (int m = 0; m < 4; m++) begin
      modeSel = 2'(m);
      step(1);
      chk("R2 scan priority", testRailOut, 14'h3234);
    end
    scanSoSer = 0; scanSoPar = 13'h0F0F; step(1);
    chk("R2 scan data", testRailOut, 14'h0F0F);
    scanMode = 0;
  endtask

  task automatic tOutHold();
    modeSel = 2'b00; resultIn = 12'h123; underIn = 0; overIn = 0;
    step(1);
    chk("R7 preload", testRailOut, 14'h0123);
    holdOut = 1; resultIn = 12'hABC; overIn = 1;
    step(1);
    modeSel = 2'b11; scanMode = 1;
    step(2);
    chk("R7 held", testRailOut, 14'h0123);
    scanMode = 0; modeSel = 2'b00; holdOut = 0;
    step(1);
    chk("R7 released", testRailOut, 14'h2ABC);
  endtask

  task automatic tInHold();
    testRailIn = 14'h2A55; step(1);
    chk("R8 capture", {scanSiSer, scanSiPar}, 14'h2A55);
    holdIn = 1; testRailIn = 14'h15AA; step(2);
    chk("R8 held", {scanSiSer, scanSiPar}, 14'h2A55);
    holdIn = 0; step(1);
    chk("R8 released", {scanSiSer, scanSiPar}, 14'h15AA);
  endtask

  initial begin
    fork
      begin
        step(1);
        tReset();
        tResult();
        tSubs();
        tScan();
        tOutHold();
        tInHold();
      end
      begin
        step(5000);
        nChecks++; nFails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule